// File: doc/BRIEF.md
# Predicated Vector Floating-Point Compare Unit

This unit takes two 128-bit vectors, a 16-bit governing predicate and one instruction word from the floating-point vector compare group. The word selects a relation and a lane width of 16, 32 or 64 bits. The unit evaluates the selected IEEE-754 relation on every lane that the predicate enables. It returns a 16-bit result predicate and a flag that reports an invalid operation. Predicates carry one bit per vector byte. A lane is addressed by the bit of its lowest byte.

Seven relations are available:

- four signalling ones: ordered greater-or-equal and greater-than, each on signed values or on magnitudes;
- three quiet ones: equal, not-equal and unordered.

A word the group does not define produces an all-zero result, a clear invalid flag and the undefined-instruction output. The result appears one clock after the input strobe, with a matching output strobe. The register index fields of the word are not used here; the register file sits outside the block.

Top module: `vfcmp_unit`

## Requirements
- R1: A word is accepted only when bits [31:24] equal 8'b01100101 and bit 21 is 0. The pair {bits [15:13], bit 4} selects the relation: 010/0 GE, 010/1 GT, 011/0 EQ, 011/1 NE, 110/0 unordered, 110/1 magnitude GE, 111/1 magnitude GT. Any other word sets `out_undef` with `out_pred` all zero and `out_invalid` low.
- R2: Bits [23:22] give the lane width: 01 is 16-bit, 10 is 32-bit and 11 is 64-bit. 00 is treated as an undefined word, as in R1.
- R3: Lane k of width W bytes occupies vector bytes k*W to k*W+W-1, little-endian. The lane is active when `pred[k*W]` is 1. Its result goes to `out_pred[k*W]`, and the other W-1 bits of that lane are 0.
- R4: An inactive lane yields a 0 result bit and never contributes to `out_invalid`, whatever its operands hold.
- R5: GE and GT are true when the first operand is greater than or equal to the second, or strictly greater, as signed IEEE values. +0 and -0 are equal, and infinities order at the ends.
- R6: Magnitude GE and GT apply the R5 tests after clearing both sign bits.
- R7: GE, GT and both magnitude relations are signalling. Any NaN on an active lane makes that lane false and sets `out_invalid`.
- R8: EQ, NE and unordered are quiet. They set `out_invalid` only for a signalling NaN, which is a NaN whose fraction MSB is 0. Unordered is true when either operand is a NaN. NE is true for unordered pairs, and EQ is false for them.
- R9: Results, `out_invalid` and `out_undef` are registered. `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| instr | input | 32 | Compare-group instruction word |
| src_a | input | 128 | First operand vector |
| src_b | input | 128 | Second operand vector |
| pred | input | 16 | Governing predicate, one bit per byte |
| out_valid | output | 1 | Result strobe |
| out_pred | output | 16 | Result predicate |
| out_invalid | output | 1 | Invalid-operation flag |
| out_undef | output | 1 | Undefined instruction word |

## Verification
The bench aims at the signed-zero pair. A design that ordered raw sign-magnitude keys would call -0 less than +0, and would fail EQ and GE on that pair. It mixes quiet and signalling NaNs across all seven relations. This exposes a design that raises invalid on a quiet NaN in EQ, NE or unordered, or that fails to raise it in the ordered relations. Predicates that set only the non-leading byte of each lane, and inactive lanes full of signalling NaNs, catch a design that takes the lane's enable from the wrong bit or that evaluates disabled lanes. Undefined opcodes, a wrong prefix, bit 21 set and size 00 must each give an empty result with only the undefined flag set.

// File: rtl/vfcmp_pkg.sv
package vfcmp_pkg;

    typedef enum logic [2:0] {
        REL_GE, REL_GT, REL_EQ, REL_NE, REL_UO, REL_AGE, REL_AGT
    } rel_e;

    typedef enum logic [1:0] {
        SZ_NONE = 2'b00,
        SZ_H    = 2'b01,
        SZ_S    = 2'b10,
        SZ_D    = 2'b11
    } esz_e;

    typedef struct packed {
        logic ok;
        rel_e rel;
        esz_e esz;
    } dec_t;

    localparam logic [7:0] GRP_PREFIX = 8'b01100101;

    // Ordered relations raise invalid on any NaN.
    function automatic logic rel_signalling(rel_e r);
        return (r == REL_GE) || (r == REL_GT) || (r == REL_AGE) || (r == REL_AGT);
    endfunction

    function automatic logic rel_magnitude(rel_e r);
        return (r == REL_AGE) || (r == REL_AGT);
    endfunction

endpackage

// File: rtl/vfcmp_decode.sv
module vfcmp_decode
    import vfcmp_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic unused_reg_fields;
    assign unused_reg_fields = ^{instr[20:16], instr[12:5], instr[3:0]};

    always_comb begin
        logic sel_ok;
        dec.rel = REL_GE;
        sel_ok  = 1'b1;
        case ({instr[15:13], instr[4]})
            4'b0100: dec.rel = REL_GE;
            4'b0101: dec.rel = REL_GT;
            4'b0110: dec.rel = REL_EQ;
            4'b0111: dec.rel = REL_NE;
            4'b1100: dec.rel = REL_UO;
            4'b1101: dec.rel = REL_AGE;
            4'b1111: dec.rel = REL_AGT;
            default: sel_ok  = 1'b0;
        endcase
        dec.esz = esz_e'(instr[23:22]);
        dec.ok  = sel_ok && (instr[31:24] == GRP_PREFIX) && !instr[21]
                  && (instr[23:22] != 2'b00);
    end
endmodule

// File: rtl/vfcmp_lane.sv
module vfcmp_lane
    import vfcmp_pkg::*;
#(
    parameter int W  = 16,
    parameter int EW = 5
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  rel_e         rel,
    input  logic         active,
    output logic         res,
    output logic         inv
);
    localparam int FW = W - 1 - EW;

    logic [W-1:0] ma, mb, ka, kb;
    logic nan_a, nan_b, snan_a, snan_b, unord, zero_both, eq_o, gt_o, r;

    always_comb begin
        nan_a  = (&a[W-2:FW]) && (|a[FW-1:0]);
        nan_b  = (&b[W-2:FW]) && (|b[FW-1:0]);
        snan_a = nan_a && !a[FW-1];
        snan_b = nan_b && !b[FW-1];
        unord  = nan_a || nan_b;

        ma = rel_magnitude(rel) ? {1'b0, a[W-2:0]} : a;
        mb = rel_magnitude(rel) ? {1'b0, b[W-2:0]} : b;

        // Monotonic keys: negative values invert, positive flip sign only.
        ka = ma[W-1] ? ~ma : {1'b1, ma[W-2:0]};
        kb = mb[W-1] ? ~mb : {1'b1, mb[W-2:0]};

        zero_both = ~|ma[W-2:0] && ~|mb[W-2:0];
        eq_o = zero_both || (ma == mb);
        gt_o = !zero_both && (ka > kb);

        case (rel)
            REL_GE, REL_AGE: r = !unord && (gt_o || eq_o);
            REL_GT, REL_AGT: r = !unord && gt_o;
            REL_EQ:          r = !unord && eq_o;
            REL_NE:          r = unord || !eq_o;
            REL_UO:          r = unord;
            default:         r = 1'b0;
        endcase

        res = active && r;
        inv = active && (rel_signalling(rel) ? unord : (snan_a || snan_b));
    end
endmodule

// File: rtl/vfcmp_unit.sv
module vfcmp_unit
    import vfcmp_pkg::*;
#(
    parameter int VBYTES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [31:0]         instr,
    input  logic [VBYTES*8-1:0] src_a,
    input  logic [VBYTES*8-1:0] src_b,
    input  logic [VBYTES-1:0]   pred,
    output logic                out_valid,
    output logic [VBYTES-1:0]   out_pred,
    output logic                out_invalid,
    output logic                out_undef
);
    localparam int NH = VBYTES / 2;
    localparam int NS = VBYTES / 4;
    localparam int ND = VBYTES / 8;

    function automatic logic [VBYTES-1:0] lane_mask(int step);
        logic [VBYTES-1:0] m;
        m = '0;
        for (int i = 0; i < VBYTES; i += step) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [VBYTES-1:0] MASK_H = lane_mask(2);
    localparam logic [VBYTES-1:0] MASK_D = lane_mask(8);

    typedef struct packed {
        logic              valid;
        logic [VBYTES-1:0] pred;
        logic              inv;
        logic              undef;
    } st_t;

    st_t  st_d, st_q;
    dec_t dec;

    vfcmp_decode u_dec (.instr(instr), .dec(dec));

    logic [NH-1:0] lres_h, linv_h;
    logic [NS-1:0] lres_s, linv_s;
    logic [ND-1:0] lres_d, linv_d;

    for (genvar i = 0; i < NH; i++) begin : g_half
        vfcmp_lane #(.W(16), .EW(5)) u_lane (
            .a(src_a[16*i +: 16]), .b(src_b[16*i +: 16]), .rel(dec.rel),
            .active(pred[2*i]), .res(lres_h[i]), .inv(linv_h[i]));
    end
    for (genvar i = 0; i < NS; i++) begin : g_single
        vfcmp_lane #(.W(32), .EW(8)) u_lane (
            .a(src_a[32*i +: 32]), .b(src_b[32*i +: 32]), .rel(dec.rel),
            .active(pred[4*i]), .res(lres_s[i]), .inv(linv_s[i]));
    end
    for (genvar i = 0; i < ND; i++) begin : g_double
        vfcmp_lane #(.W(64), .EW(11)) u_lane (
            .a(src_a[64*i +: 64]), .b(src_b[64*i +: 64]), .rel(dec.rel),
            .active(pred[8*i]), .res(lres_d[i]), .inv(linv_d[i]));
    end

    logic [VBYTES-1:0] spread_h, spread_s, spread_d;

    always_comb begin
        spread_h = '0;
        spread_s = '0;
        spread_d = '0;
        for (int i = 0; i < NH; i++) spread_h[2*i] = lres_h[i];
        for (int i = 0; i < NS; i++) spread_s[4*i] = lres_s[i];
        for (int i = 0; i < ND; i++) spread_d[8*i] = lres_d[i];

        st_d       = '0;
        st_d.valid = in_valid;
        if (in_valid) begin
            if (!dec.ok) begin
                st_d.undef = 1'b1;
            end else begin
                case (dec.esz)
                    SZ_H: begin st_d.pred = spread_h; st_d.inv = |linv_h; end
                    SZ_S: begin st_d.pred = spread_s; st_d.inv = |linv_s; end
                    SZ_D: begin st_d.pred = spread_d; st_d.inv = |linv_d; end
                    default: st_d.undef = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.valid;
    assign out_pred    = st_q.pred;
    assign out_invalid = st_q.inv;
    assign out_undef   = st_q.undef;

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r4_inactive_zero: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_pred & ~$past(pred)) == '0));
    a_r1_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dec.ok) |=> (out_undef && out_pred == '0 && !out_invalid));
    a_r2_size_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[23:22] == 2'b00) |=> out_undef);
    a_r3_half_align: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec.ok && dec.esz == SZ_H) |=> ((out_pred & ~MASK_H) == '0));
    a_r3_dbl_align: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec.ok && dec.esz == SZ_D) |=> ((out_pred & ~MASK_D) == '0));

endmodule

// File: tb/vfcmp_unit_test.sv
module vfcmp_unit_test;

    typedef struct {
        logic [15:0] p;
        logic        inv;
        logic        undef;
        int          due;
        string       tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] src_a = '0, src_b = '0;
    logic [15:0]  pred = '0;
    logic         out_valid, out_invalid, out_undef;
    logic [15:0]  out_pred;

    int   n_checks = 0, n_fail = 0, cyc = 0;
    bit   done = 0;
    exp_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vfcmp_unit uut (.clk, .rst_n, .in_valid, .instr, .src_a, .src_b, .pred,
                    .out_valid, .out_pred, .out_invalid, .out_undef);

    // Relation codes: 0 GE, 1 GT, 2 EQ, 3 NE, 4 UO, 5 |GE|, 6 |GT|.
    function automatic logic [31:0] mk(int rel, logic [1:0] sz);
        logic [2:0] op; logic sub;
        case (rel)
            0: begin op = 3'b010; sub = 0; end
            1: begin op = 3'b010; sub = 1; end
            2: begin op = 3'b011; sub = 0; end
            3: begin op = 3'b011; sub = 1; end
            4: begin op = 3'b110; sub = 0; end
            5: begin op = 3'b110; sub = 1; end
            default: begin op = 3'b111; sub = 1; end
        endcase
        return {8'b01100101, sz, 1'b0, 5'd3, op, 3'd2, 5'd7, sub, 4'd5};
    endfunction

    function automatic void cmp_elem(logic [63:0] x, logic [63:0] y, int w, int rel,
                                     output bit r, output bit iv);
        int ew, fw; logic [63:0] mx, my, fx, fy, ex, ey, emax;
        bit sx, sy, nx, ny, snx, sny, un, gt, eq, sig;
        ew = (w == 16) ? 5 : (w == 32) ? 8 : 11;
        fw = w - 1 - ew;
        mx = x & ((64'd1 << (w-1)) - 1);
        my = y & ((64'd1 << (w-1)) - 1);
        fx = x & ((64'd1 << fw) - 1);
        fy = y & ((64'd1 << fw) - 1);
        ex = mx >> fw; ey = my >> fw; emax = (64'd1 << ew) - 1;
        nx = (ex == emax) && (fx != 0);
        ny = (ey == emax) && (fy != 0);
        snx = nx && (((fx >> (fw-1)) & 1) == 0);
        sny = ny && (((fy >> (fw-1)) & 1) == 0);
        un = nx || ny;
        sx = (rel >= 5) ? 1'b0 : x[w-1];
        sy = (rel >= 5) ? 1'b0 : y[w-1];
        if (mx == 0 && my == 0) begin eq = 1; gt = 0; end
        else if (sx != sy)      begin eq = 0; gt = sy; end
        else if (!sx)           begin eq = (mx == my); gt = (mx > my); end
        else                    begin eq = (mx == my); gt = (mx < my); end
        sig = (rel == 0 || rel == 1 || rel == 5 || rel == 6);
        case (rel)
            0, 5:    r = !un && (gt || eq);
            1, 6:    r = !un && gt;
            2:       r = !un && eq;
            3:       r = un || !eq;
            default: r = un;
        endcase
        iv = sig ? un : (snx || sny);
    endfunction

    function automatic void model(logic [31:0] iw, logic [127:0] a, logic [127:0] b,
                                  logic [15:0] pg, output exp_t e);
        int rel, w, step; bit ok, r, iv; logic [63:0] x, y;
        e.p = '0; e.inv = 0; e.undef = 0;
        ok = 1; rel = 0;
        case ({iw[15:13], iw[4]})
            4'b0100: rel = 0; 4'b0101: rel = 1; 4'b0110: rel = 2; 4'b0111: rel = 3;
            4'b1100: rel = 4; 4'b1101: rel = 5; 4'b1111: rel = 6;
            default: ok = 0;
        endcase
        if (iw[31:24] != 8'b01100101 || iw[21] || iw[23:22] == 2'b00) ok = 0;
        if (!ok) begin e.undef = 1; return; end
        w = 8 << iw[23:22];
        step = w / 8;
        for (int l = 0; l < 16 / step; l++) begin
            if (pg[l*step]) begin
                x = 64'(a >> (l*w)); y = 64'(b >> (l*w));
                if (w < 64) begin
                    x &= (64'd1 << w) - 1; y &= (64'd1 << w) - 1;
                end
                cmp_elem(x, y, w, rel, r, iv);
                e.p[l*step] = r;
                e.inv |= iv;
            end
        end
    endfunction

    task automatic send(logic [31:0] iw, logic [127:0] a, logic [127:0] b,
                        logic [15:0] pg, string tag);
        exp_t e;
        @(negedge clk);
        instr = iw; src_a = a; src_b = b; pred = pg; in_valid = 1'b1;
        model(iw, a, b, pg, e);
        e.due = cyc + 1;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                n_checks++;
                if (sb.size() == 0) begin
                    n_fail++;
                    $display("FAIL R9 spurious out_valid: actual 1 expected 0");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (e.due != cyc || out_pred !== e.p || out_invalid !== e.inv
                        || out_undef !== e.undef) begin
                        n_fail++;
                        $display("FAIL %s: actual cyc=%0d pred=%h inv=%b undef=%b expected cyc=%0d pred=%h inv=%b undef=%b",
                                 e.tag, cyc, out_pred, out_invalid, out_undef,
                                 e.due, e.p, e.inv, e.undef);
                    end
                end
            end else if (sb.size() != 0 && sb[0].due <= cyc) begin
                void'(sb.pop_front());
                n_checks++; n_fail++;
                $display("FAIL R9 missing out_valid: actual 0 expected 1");
            end
        end
    end

    function automatic logic [63:0] pool(int w, int k);
        logic [15:0] h[12] = '{16'h3C00, 16'h4000, 16'hBC00, 16'h0000, 16'h8000, 16'h7E00,
                               16'h7C01, 16'h7C00, 16'hFC00, 16'hC000, 16'h0001, 16'h8001};
        logic [31:0] s[12] = '{32'h3F800000, 32'h40000000, 32'hBF800000, 32'h0, 32'h80000000,
                               32'h7FC00000, 32'h7F800001, 32'h7F800000, 32'hFF800000,
                               32'hC0000000, 32'h1, 32'h80000001};
        logic [63:0] d[12] = '{64'h3FF0000000000000, 64'h4000000000000000, 64'hBFF0000000000000,
                               64'h0, 64'h8000000000000000, 64'h7FF8000000000000,
                               64'h7FF0000000000001, 64'h7FF0000000000000, 64'hFFF0000000000000,
                               64'hC000000000000000, 64'h1, 64'h8000000000000001};
        if (w == 16) return 64'(h[k]);
        if (w == 32) return 64'(s[k]);
        return d[k];
    endfunction

    function automatic logic [127:0] fill(int w, int k);
        logic [127:0] v = '0;
        for (int l = 0; l < 128 / w; l++)
            v |= 128'(pool(w, (k < 0) ? int'($urandom_range(11)) : k)) << (l*w);
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_pred !== 16'h0) begin
            n_fail++;
            $display("FAIL R9 reset state: actual valid=%b pred=%h expected 0 0", out_valid, out_pred);
        end
        rst_n = 1'b1;
        idle(2);

        // R5 R6 R7 R8: random mixes of special values across all relations and sizes.
        for (int rel = 0; rel < 7; rel++)
            for (int sz = 1; sz < 4; sz++)
                for (int it = 0; it < 6; it++)
                    send(mk(rel, 2'(sz)), fill(8 << sz, -1), fill(8 << sz, -1),
                         16'($urandom), (rel < 2) ? "R5 R7" : (rel >= 5) ? "R6 R7" : "R8");
        idle(2);

        // R5: +0 against -0 is equal, GE true, GT false.
        send(mk(2, 2'b01), fill(16, 3), fill(16, 4), 16'hFFFF, "R5 zero EQ");
        send(mk(0, 2'b10), fill(32, 4), fill(32, 3), 16'hFFFF, "R5 zero GE");
        send(mk(1, 2'b11), fill(64, 3), fill(64, 4), 16'hFFFF, "R5 zero GT");
        // R6: |-2| > |1| though -2 < 1.
        send(mk(6, 2'b01), fill(16, 9), fill(16, 0), 16'hFFFF, "R6 magnitude GT");
        send(mk(1, 2'b01), fill(16, 9), fill(16, 0), 16'hFFFF, "R5 signed GT");
        // R7/R8: quiet NaN raises invalid only for ordered relations.
        send(mk(0, 2'b10), fill(32, 5), fill(32, 0), 16'hFFFF, "R7 qNaN GE");
        send(mk(3, 2'b10), fill(32, 5), fill(32, 0), 16'hFFFF, "R8 qNaN NE");
        send(mk(2, 2'b11), fill(64, 6), fill(64, 6), 16'hFFFF, "R8 sNaN EQ");
        send(mk(4, 2'b01), fill(16, 0), fill(16, 5), 16'hFFFF, "R8 qNaN UO");
        // R4: inactive lanes with signalling NaNs.
        send(mk(0, 2'b01), fill(16, 6), fill(16, 6), 16'h0000, "R4 all inactive");
        send(mk(5, 2'b10), fill(32, 6), fill(32, 0), 16'hEEEE, "R4 non-lead bits only");
        // R3: enable taken from the lane's lowest byte only.
        send(mk(2, 2'b11), fill(64, 0), fill(64, 0), 16'hFEFE, "R3 dbl lead bits clear");
        send(mk(2, 2'b11), fill(64, 0), fill(64, 0), 16'h0101, "R3 dbl lead bits set");
        send(mk(3, 2'b01), fill(16, 0), fill(16, 1), 16'h5555, "R3 half layout");
        idle(1);
        // R1 / R2: undefined words.
        send(mk(0, 2'b01) & ~32'h0000_E010, fill(16, 6), fill(16, 6), 16'hFFFF, "R1 op 000/0");
        send((mk(0, 2'b01) & ~32'h0000_E010) | 32'h0000_E000, fill(16, 6), fill(16, 6), 16'hFFFF, "R1 op 111/0");
        send(mk(2, 2'b01) | 32'h0020_0000, fill(16, 6), fill(16, 6), 16'hFFFF, "R1 bit21 set");
        send(mk(2, 2'b01) ^ 32'h0100_0000, fill(16, 6), fill(16, 6), 16'hFFFF, "R1 wrong prefix");
        send(mk(4, 2'b00), fill(16, 6), fill(16, 6), 16'hFFFF, "R2 size 00");
        send(mk(4, 2'b01), fill(16, 6), fill(16, 0), 16'hFFFF, "R2 size 01 after undef");
        idle(4);

        n_checks++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R9 results outstanding: actual %0d expected 0", sb.size());
        end
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule